// File: doc/BRIEF.md
# Dual-Mode Interrupt Vector Router

The router collects 256 external interrupt vectors and steers each one to an interrupt pin of one of eight CPU targets. Every vector owns four pieces of state: a pending flag, an enable flag, an 8-bit target byte and a 4-bit pin field. A vector is delivered when it is both pending and enabled. Each CPU has sixteen pin lines, and all vectors that land on the same CPU and pin are ORed onto one registered output line.

The target byte can be read in two ways, chosen at run time through a configuration word. In the compatibility form, the upper nibble names a node and the lower nibble is a mask over cores 0 to 3. Only node 0 exists here. In the encoded form, the whole byte is a binary CPU number. The pin field works the same way: it is either a mask over pins 0 to 3, or a binary pin number from 0 to 15. A read-only capability word reports which encoded forms the instance supports. A configuration bit for an unsupported form is dropped when it is written.

Software reaches all of this through a 32-bit register port with a valid/ready handshake. Reads return one cycle after they are accepted.

Top module: `ivr_router`

## Requirements
- R1: After reset, every CPU pin output and the error flag are 0, the configuration word reads 0, every enable word reads 0, and `reg_ready` is 1.
- R2: A high level on `vec_in[v]` at a clock edge sets the pending flag of vector v. Status word k sits at byte address 0x100+4k and holds vector 32k+b at bit b. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When an input set and a clear of the same vector fall in the same cycle, the set wins.
- R3: Enable word k sits at byte address 0x000+4k and holds vector 32k+b at bit b. A pending vector whose enable bit is 0 keeps its pending flag but drives no output.
- R4: Target word k sits at byte address 0x200+4k and holds the byte of vector 4k+j in bits [8j+7:8j].
- R5: With configuration bit 1 clear, a vector reaches CPU c (c in 0..3) on each pin it selects when the upper target nibble is 0 and bit c of the lower nibble is 1. Several mask bits may be set at once. A nonzero upper nibble delivers nothing, and CPUs 4..7 are never reached.
- R6: With configuration bit 1 set, the target byte is a binary CPU number. A number of 8 or more delivers nothing and sets `route_err` while the vector is pending and enabled. `route_err` then stays 1 until reset.
- R7: Pin word k sits at byte address 0x300+4k and holds the pin field of vector 8k+j in bits [4j+3:4j]. With configuration bit 0 clear, field bit p selects pin p (p in 0..3). With bit 0 set, the field is a binary pin number from 0 to 15.
- R8: The capability word at 0x400 reads bit 0 = pin encoding supported and bit 1 = CPU encoding supported, taken from the instance parameters. Writes to it change nothing.
- R9: The configuration word at 0x404 is read/write. A bit whose capability bit is 0 reads back 0 and has no effect on delivery.
- R10: Pin line p of CPU c is `cpu_irq[16c+p]`. The outputs are registered: a register write or a pending change accepted at one edge shows at the outputs after the following edge. If no vector was pending and enabled in the previous cycle, all outputs are 0.
- R11: An accepted read (`reg_valid` and not `reg_write`) raises `rd_valid` for one cycle after the next edge, with the data in `rd_data`. Unmapped or misaligned addresses, including word indices beyond an array, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_in | input | 256 | Vector request lines, one per vector |
| reg_valid | input | 1 | Register request valid |
| reg_ready | output | 1 | Register request accepted (high out of reset) |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| cpu_irq | output | 128 | Pin lines, bit 16c+p is pin p of CPU c |
| route_err | output | 1 | Sticky flag for an out-of-range encoded CPU target |

## Verification
Directed cases each drive a single vector and change one setting at a time. This separates mask-style core selection from binary CPU selection, mask-style pin selection from binary pin selection, and a zero node nibble from a nonzero one, so a swapped or mis-ordered decode shows up as a wrong output bit. Targeted sequences cover the points where ordering matters. One issues a set and a clear of the same vector in the same cycle. One samples the outputs one cycle after a write, and again one cycle later. One routes to an out-of-range CPU number and then moves the vector back to a valid target, which shows whether the error flag stays set. A seeded random phase then mixes enable, target, pin, configuration, request and clear operations. After every operation it compares all 128 output lines and the error flag against a model in the bench. It also reads registers back, which exposes errors in lane and bit packing. A second instance built without any encoded form shows that its capability word reads 0 and that its configuration bits cannot be set.

// File: rtl/ivr_pkg.sv
`timescale 1ns/1ps
package ivr_pkg;

    localparam int PIN_LINES    = 16;
    localparam int PIN_FLD_W    = 4;
    localparam int ROUTE_W      = 8;
    localparam int LEGACY_CORES = 4;
    localparam int ADDR_W       = 12;
    localparam int DATA_W       = 32;
    localparam int IDX_W        = 6;

    typedef enum logic [2:0] {
        RG_EN,
        RG_ST,
        RG_RT,
        RG_PIN,
        RG_FEAT,
        RG_CFG,
        RG_NONE
    } reg_region_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_req_t;

    // bit 1 selects binary CPU numbers, bit 0 selects binary pin numbers
    typedef struct packed {
        logic cpu_enc;
        logic pin_enc;
    } mode_cfg_t;

    function automatic reg_region_e region_of(input logic [ADDR_W-1:0] a);
        reg_region_e r;
        r = RG_NONE;
        if (a[1:0] == 2'b00) begin
            case (a[11:8])
                4'h0: r = RG_EN;
                4'h1: r = RG_ST;
                4'h2: r = RG_RT;
                4'h3: r = RG_PIN;
                4'h4: begin
                    if (a[7:2] == 6'd0)      r = RG_FEAT;
                    else if (a[7:2] == 6'd1) r = RG_CFG;
                    else                     r = RG_NONE;
                end
                default: r = RG_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return a[IDX_W+1:2];
    endfunction

    // pin field to pin lines: mask over the low pins, or a binary pin number
    function automatic logic [PIN_LINES-1:0] pin_lines(input logic [PIN_FLD_W-1:0] fld,
                                                       input logic enc);
        logic [PIN_LINES-1:0] r;
        if (enc) r = PIN_LINES'(1) << fld;
        else     r = {{(PIN_LINES-PIN_FLD_W){1'b0}}, fld};
        return r;
    endfunction

endpackage

// File: rtl/ivr_pending.sv
`timescale 1ns/1ps
module ivr_pending #(
    parameter int NUM_VEC = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] vec_in,
    input  logic [NUM_VEC-1:0] clr,
    output logic [NUM_VEC-1:0] pend
);

    logic [NUM_VEC-1:0] pend_q;

    // a request in the same cycle as a clear keeps the flag set
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr) | vec_in;
    end

    assign pend = pend_q;

    // R2
    pending_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|vec_in) |=> ((pend & $past(vec_in)) == $past(vec_in)));

    // R2
    pending_keep_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(pend) & ~$past(clr)) == ($past(pend) & ~$past(clr))));

endmodule

// File: rtl/ivr_regs.sv
`timescale 1ns/1ps
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter bit PIN_SUP = 1'b1,
    parameter bit CPU_SUP = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  reg_req_t                     req,
    input  logic [NUM_VEC-1:0]           pend,
    output logic [NUM_VEC-1:0]           en,
    output logic [NUM_VEC*ROUTE_W-1:0]   route,
    output logic [NUM_VEC*PIN_FLD_W-1:0] pin,
    output mode_cfg_t                    cfg,
    output logic [NUM_VEC-1:0]           clr,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data
);

    localparam int EN_WORDS  = NUM_VEC / DATA_W;
    localparam int RT_WORDS  = NUM_VEC * ROUTE_W / DATA_W;
    localparam int PIN_WORDS = NUM_VEC * PIN_FLD_W / DATA_W;
    localparam logic [1:0] SUP_MASK = {CPU_SUP, PIN_SUP};

    logic [EN_WORDS-1:0][DATA_W-1:0]  en_q;
    logic [RT_WORDS-1:0][DATA_W-1:0]  route_q;
    logic [PIN_WORDS-1:0][DATA_W-1:0] pin_q;
    logic [EN_WORDS-1:0][DATA_W-1:0]  clr_w;
    mode_cfg_t                        cfg_q;

    reg_region_e      rgn;
    logic [IDX_W-1:0] widx;
    logic             do_wr;
    logic             do_rd;
    logic [DATA_W-1:0] rd_n;
    logic             rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;

    assign rgn   = region_of(req.addr);
    assign widx  = word_of(req.addr);
    assign do_wr = req_valid & req.wr;
    assign do_rd = req_valid & ~req.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            route_q <= '0;
            pin_q   <= '0;
            cfg_q   <= '0;
        end else if (do_wr) begin
            case (rgn)
                RG_EN: begin
                    for (int w = 0; w < EN_WORDS; w++)
                        if (widx == IDX_W'(w)) en_q[w] <= req.data;
                end
                RG_RT: begin
                    for (int w = 0; w < RT_WORDS; w++)
                        if (widx == IDX_W'(w)) route_q[w] <= req.data;
                end
                RG_PIN: begin
                    for (int w = 0; w < PIN_WORDS; w++)
                        if (widx == IDX_W'(w)) pin_q[w] <= req.data;
                end
                RG_CFG: cfg_q <= mode_cfg_t'(req.data[1:0] & SUP_MASK);
                default: ;
            endcase
        end
    end

    // write-one-to-clear strobes for the pending bank
    always_comb begin
        clr_w = '0;
        if (do_wr && rgn == RG_ST) begin
            for (int w = 0; w < EN_WORDS; w++)
                if (widx == IDX_W'(w)) clr_w[w] = req.data;
        end
    end

    always_comb begin
        rd_n = '0;
        case (rgn)
            RG_EN: begin
                for (int w = 0; w < EN_WORDS; w++)
                    if (widx == IDX_W'(w)) rd_n = en_q[w];
            end
            RG_ST: begin
                for (int w = 0; w < EN_WORDS; w++)
                    if (widx == IDX_W'(w)) rd_n = pend[w*DATA_W +: DATA_W];
            end
            RG_RT: begin
                for (int w = 0; w < RT_WORDS; w++)
                    if (widx == IDX_W'(w)) rd_n = route_q[w];
            end
            RG_PIN: begin
                for (int w = 0; w < PIN_WORDS; w++)
                    if (widx == IDX_W'(w)) rd_n = pin_q[w];
            end
            RG_FEAT: rd_n = {{(DATA_W-2){1'b0}}, SUP_MASK};
            RG_CFG:  rd_n = {{(DATA_W-2){1'b0}}, cfg_q};
            default: rd_n = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= do_rd;
            if (do_rd) rd_data_q <= rd_n;
        end
    end

    assign en       = en_q;
    assign route    = route_q;
    assign pin      = pin_q;
    assign cfg      = cfg_q;
    assign clr      = clr_w;
    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

    // R11
    read_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req.wr) |=> rd_valid);

    // R11
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req.wr) |=> !rd_valid);

endmodule

// File: rtl/ivr_fabric.sv
`timescale 1ns/1ps
module ivr_fabric
    import ivr_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int NUM_CPU = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_VEC-1:0]               pend,
    input  logic [NUM_VEC-1:0]               en,
    input  logic [NUM_VEC*ROUTE_W-1:0]       route,
    input  logic [NUM_VEC*PIN_FLD_W-1:0]     pin,
    input  mode_cfg_t                        cfg,
    output logic [NUM_CPU*PIN_LINES-1:0]     cpu_irq,
    output logic                             route_err
);

    localparam int OUT_W = NUM_CPU * PIN_LINES;

    logic [NUM_VEC-1:0]   act;
    logic [NUM_VEC-1:0]   bad;
    logic [NUM_CPU-1:0]   tgt_cpu [NUM_VEC];
    logic [PIN_LINES-1:0] tgt_pin [NUM_VEC];
    logic [OUT_W-1:0]     irq_n;
    logic [OUT_W-1:0]     irq_q;
    logic                 err_q;

    assign act = pend & en;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        logic [ROUTE_W-1:0]   rb;
        logic [PIN_FLD_W-1:0] pf;
        logic [NUM_CPU-1:0]   leg_hit;
        logic [NUM_CPU-1:0]   enc_hit;

        assign rb = route[v*ROUTE_W +: ROUTE_W];
        assign pf = pin[v*PIN_FLD_W +: PIN_FLD_W];

        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            assign enc_hit[c] = (rb == ROUTE_W'(c));
            if (c < LEGACY_CORES) begin : g_near
                assign leg_hit[c] = (rb[ROUTE_W-1:LEGACY_CORES] == '0) & rb[c];
            end else begin : g_far
                assign leg_hit[c] = 1'b0;
            end
        end

        assign tgt_cpu[v] = cfg.cpu_enc ? enc_hit : leg_hit;
        assign tgt_pin[v] = pin_lines(pf, cfg.pin_enc);
        assign bad[v]     = cfg.cpu_enc & ({1'b0, rb} >= 9'(NUM_CPU));
    end

    // per CPU, OR the pin lines of every vector aimed at it
    always_comb begin
        irq_n = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                irq_n[c*PIN_LINES +: PIN_LINES] = irq_n[c*PIN_LINES +: PIN_LINES]
                    | (tgt_pin[v] & {PIN_LINES{act[v] & tgt_cpu[v][c]}});
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            err_q <= 1'b0;
        end else begin
            irq_q <= irq_n;
            err_q <= err_q | (|(act & bad));
        end
    end

    assign cpu_irq   = irq_q;
    assign route_err = err_q;

    // R10
    quiet_out_chk: assert property (@(posedge clk) disable iff (rst)
        (act == '0) |=> (cpu_irq == '0));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        route_err |=> route_err);

    // R7
    single_target_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.cpu_enc && cfg.pin_enc && $countones(act) == 1) |=> ($countones(cpu_irq) <= 1));

    if (NUM_CPU > LEGACY_CORES) begin : g_reach
        // R5
        legacy_reach_chk: assert property (@(posedge clk) disable iff (rst)
            !cfg.cpu_enc |=> (cpu_irq[OUT_W-1:LEGACY_CORES*PIN_LINES] == '0));
    end

endmodule

// File: rtl/ivr_router.sv
`timescale 1ns/1ps
module ivr_router
    import ivr_pkg::*;
#(
    parameter int NUM_VEC     = 256,
    parameter int NUM_CPU     = 8,
    parameter bit PIN_ENC_SUP = 1'b1,
    parameter bit CPU_ENC_SUP = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_VEC-1:0]           vec_in,
    input  logic                         reg_valid,
    output logic                         reg_ready,
    input  logic                         reg_write,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [DATA_W-1:0]            reg_wdata,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NUM_CPU*PIN_LINES-1:0] cpu_irq,
    output logic                         route_err
);

    reg_req_t                     req;
    logic                         req_valid;
    logic [NUM_VEC-1:0]           pend;
    logic [NUM_VEC-1:0]           en;
    logic [NUM_VEC-1:0]           clr;
    logic [NUM_VEC*ROUTE_W-1:0]   route;
    logic [NUM_VEC*PIN_FLD_W-1:0] pin;
    mode_cfg_t                    cfg;

    assign reg_ready = ~rst;
    assign req_valid = reg_valid & ~rst;
    assign req       = {reg_write, reg_addr, reg_wdata};

    ivr_pending #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .vec_in (vec_in),
        .clr    (clr),
        .pend   (pend)
    );

    ivr_regs #(
        .NUM_VEC (NUM_VEC),
        .PIN_SUP (PIN_ENC_SUP),
        .CPU_SUP (CPU_ENC_SUP)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .pend      (pend),
        .en        (en),
        .route     (route),
        .pin       (pin),
        .cfg       (cfg),
        .clr       (clr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    ivr_fabric #(
        .NUM_VEC (NUM_VEC),
        .NUM_CPU (NUM_CPU)
    ) u_fabric (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend),
        .en        (en),
        .route     (route),
        .pin       (pin),
        .cfg       (cfg),
        .cpu_irq   (cpu_irq),
        .route_err (route_err)
    );

endmodule

// File: tb/sim_ivr_router.sv
`timescale 1ns/1ps
module sim_ivr_router;

    localparam int NV = 256;
    localparam int NC = 8;
    localparam int OW = NC * 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NV-1:0] vec_in = '0;
    logic          reg_valid = 1'b0;
    logic          reg_write = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_ready, rd_valid, route_err;
    logic [31:0]   rd_data;
    logic [OW-1:0] cpu_irq;
    logic          reg_ready1, rd_valid1, route_err1;
    logic [31:0]   rd_data1;
    logic [OW-1:0] cpu_irq1;

    always #2.5 clk = ~clk;

    ivr_router u0 (
        .clk(clk), .rst(rst), .vec_in(vec_in), .reg_valid(reg_valid), .reg_ready(reg_ready),
        .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .cpu_irq(cpu_irq), .route_err(route_err)
    );

    // instance without any encoded form, sharing the request bus
    ivr_router #(.PIN_ENC_SUP(1'b0), .CPU_ENC_SUP(1'b0)) u1 (
        .clk(clk), .rst(rst), .vec_in('0), .reg_valid(reg_valid), .reg_ready(reg_ready1),
        .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rd_valid(rd_valid1), .rd_data(rd_data1), .cpu_irq(cpu_irq1), .route_err(route_err1)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    bit [NV-1:0] en_m   = '0;
    bit [NV-1:0] pend_m = '0;
    bit [7:0]    rt_m [NV];
    bit [3:0]    pn_m [NV];
    bit [1:0]    cfg_m = 2'b00;
    bit          err_m = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [OW-1:0] exp_irq();
        logic [OW-1:0] o;
        logic [NC-1:0] ch;
        logic [15:0]   ph;
        o = '0;
        for (int v = 0; v < NV; v++) begin
            if (en_m[v] && pend_m[v]) begin
                ch = '0;
                if (cfg_m[1]) begin
                    if (rt_m[v] < 8) ch[rt_m[v][2:0]] = 1'b1;
                end else if (rt_m[v][7:4] == 4'h0) begin
                    ch[3:0] = rt_m[v][3:0];
                end
                ph = cfg_m[0] ? (16'd1 << pn_m[v]) : {12'b0, pn_m[v]};
                for (int c = 0; c < NC; c++)
                    if (ch[c]) o[c*16 +: 16] = o[c*16 +: 16] | ph;
            end
        end
        return o;
    endfunction

    function automatic bit [31:0] rt_word(input int w);
        return {rt_m[4*w+3], rt_m[4*w+2], rt_m[4*w+1], rt_m[4*w]};
    endfunction

    function automatic bit [31:0] pn_word(input int w);
        bit [31:0] r;
        for (int j = 0; j < 8; j++) r[j*4 +: 4] = pn_m[8*w+j];
        return r;
    endfunction

    task automatic upd_err();
        for (int v = 0; v < NV; v++)
            if (cfg_m[1] && en_m[v] && pend_m[v] && rt_m[v] >= 8) err_m = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d0, output logic [31:0] d1);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        chk(rd_valid === 1'b1, "R11 rd_valid after read", OW'(rd_valid), OW'(1));
        d0 = rd_data; d1 = rd_data1;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d0, d1;
        rd(a, d0, d1);
        chk(d0 === exp, tag, OW'(d0), OW'(exp));
    endtask

    task automatic set_en(input int w, input bit [31:0] d);
        wr(12'(12'h000 + 4*w), d); en_m[w*32 +: 32] = d; upd_err();
    endtask
    task automatic set_rt(input int w, input bit [31:0] d);
        wr(12'(12'h200 + 4*w), d);
        for (int j = 0; j < 4; j++) rt_m[4*w+j] = d[j*8 +: 8];
        upd_err();
    endtask
    task automatic set_pn(input int w, input bit [31:0] d);
        wr(12'(12'h300 + 4*w), d);
        for (int j = 0; j < 8; j++) pn_m[8*w+j] = d[j*4 +: 4];
        upd_err();
    endtask
    task automatic set_cfg(input bit [1:0] d);
        wr(12'h404, {30'b0, d}); cfg_m = d; upd_err();
    endtask
    task automatic clr_st(input int w, input bit [31:0] m);
        wr(12'(12'h100 + 4*w), m); pend_m[w*32 +: 32] = pend_m[w*32 +: 32] & ~m; upd_err();
    endtask
    task automatic pulse(input int v);
        @(negedge clk);
        vec_in[v] = 1'b1;
        @(negedge clk);
        vec_in = '0;
        pend_m[v] = 1'b1; upd_err();
    endtask

    task automatic settle(input string tag);
        logic [OW-1:0] e;
        @(negedge clk);
        @(negedge clk);
        e = exp_irq();
        chk(cpu_irq === e, tag, cpu_irq, e);
        chk(route_err === err_m, {tag, " R6 err flag"}, OW'(route_err), OW'(err_m));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d0, d1;
        logic [OW-1:0] e;
        for (int v = 0; v < NV; v++) begin rt_m[v] = '0; pn_m[v] = '0; end
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk(cpu_irq === '0, "R1 outputs after reset", cpu_irq, '0);
        chk(route_err === 1'b0, "R1 err after reset", OW'(route_err), '0);
        chk(reg_ready === 1'b1, "R1 ready", OW'(reg_ready), OW'(1));
        rd_chk(12'h404, 32'h0, "R1 config reads 0");
        rd_chk(12'h000, 32'h0, "R1 enable reads 0");

        // R8 capability word
        rd(12'h400, d0, d1);
        chk(d0 === 32'h3, "R8 capability full", OW'(d0), OW'(3));
        chk(d1 === 32'h0, "R8 capability none", OW'(d1), OW'(0));
        wr(12'h400, 32'h0);
        rd_chk(12'h400, 32'h3, "R8 write ignored");

        // R9 unsupported config bits
        set_cfg(2'b11);
        rd(12'h404, d0, d1);
        chk(d0 === 32'h3, "R9 config readback", OW'(d0), OW'(3));
        chk(d1 === 32'h0, "R9 unsupported bits dropped", OW'(d1), OW'(0));
        set_cfg(2'b00);

        // R2 request sets pending; R3 disabled vector silent
        pulse(37);
        rd_chk(12'h104, 32'h20, "R2 status bit of vector 37");
        settle("R3 disabled vector drives nothing");

        set_rt(9, 32'h0000_0100);
        set_pn(4, 32'h0010_0000);
        // R10 exact timing of the enable write
        set_en(1, 32'h20);
        chk(cpu_irq === '0, "R10 output unchanged one cycle early", cpu_irq, '0);
        @(negedge clk);
        e = exp_irq();
        chk(cpu_irq === e && e == OW'(1), "R10 output after write", cpu_irq, OW'(1));

        // R5 compatibility CPU selection
        set_rt(9, 32'h0000_0500);
        settle("R5 core mask 0101");
        set_rt(9, 32'h0000_1500);
        settle("R5 nonzero node delivers nothing");

        // R7 pin mask
        set_rt(9, 32'h0000_0100);
        set_pn(4, 32'h00A0_0000);
        settle("R7 pin mask 1010");

        // R6 binary CPU, R7 binary pin
        set_cfg(2'b10);
        set_rt(9, 32'h0000_0600);
        settle("R6 binary CPU 6");
        set_cfg(2'b11);
        settle("R7 binary pin 10");
        chk(route_err === 1'b0, "R6 no error yet", OW'(route_err), '0);
        set_rt(9, 32'h0000_0900);
        settle("R6 CPU 9 dropped");
        set_rt(9, 32'h0000_0600);
        settle("R6 error stays set");

        // R2 write-one-to-clear
        clr_st(1, 32'h20);
        settle("R2 cleared vector stops");
        rd_chk(12'h104, 32'h0, "R2 status after clear");

        // R2 set wins against same-cycle clear
        @(negedge clk);
        vec_in[40] = 1'b1;
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 12'h104; reg_wdata = 32'h100;
        @(negedge clk);
        vec_in = '0; reg_valid = 1'b0; reg_write = 1'b0;
        pend_m[40] = 1'b1; upd_err();
        rd_chk(12'h104, 32'h100, "R2 set beats clear");

        // R3 disabled keeps pending
        pulse(37);
        settle("R3 enabled vector drives");
        set_en(1, 32'h0);
        settle("R3 masked vector silent");
        rd_chk(12'h104, 32'h120, "R3 pending kept while masked");
        set_en(1, 32'h20);
        settle("R3 re-enabled vector drives again");

        // R11 unmapped reads, R4 lane packing
        rd_chk(12'h500, 32'h0, "R11 unmapped reads 0");
        rd_chk(12'h0FC, 32'h0, "R11 index beyond array reads 0");
        rd_chk(12'h226, 32'h0, "R11 misaligned reads 0");
        rd_chk(12'h224, rt_word(9), "R4 target word 9");

        // seeded random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            bit [31:0] d;
            op = $urandom % 6;
            case (op)
                0: set_en($urandom % 8, $urandom);
                1: begin
                    for (int j = 0; j < 4; j++) begin
                        bit [31:0] r;
                        r = $urandom;
                        d[j*8 +: 8] = (r[9:8] == 2'b00) ? r[7:0] : {4'h0, r[3:0]};
                    end
                    set_rt($urandom % 64, d);
                end
                2: set_pn($urandom % 32, $urandom);
                3: set_cfg(2'($urandom % 4));
                4: pulse($urandom % NV);
                default: clr_st($urandom % 8, $urandom);
            endcase
            settle("R5 R6 R7 R10 random mix");
            if (it % 8 == 0) begin
                int w;
                w = $urandom % 8;
                rd_chk(12'(12'h100 + 4*w), pend_m[w*32 +: 32], "R2 random status read");
                rd_chk(12'(12'h000 + 4*w), en_m[w*32 +: 32], "R3 random enable read");
                w = $urandom % 64;
                rd_chk(12'(12'h200 + 4*w), rt_word(w), "R4 random target read");
                w = $urandom % 32;
                rd_chk(12'(12'h300 + 4*w), pn_word(w), "R7 random pin read");
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule